// File: doc/BRIEF.md
# Quadrant-Decomposed Unsigned Multiplier with Sleep Clamp

This block multiplies two unsigned operands and returns their full-width product in the same cycle, with no clock or storage inside. The product is not written as a behavioural multiply. Each operand is split into a low half and a high half. The four half-width products (low by low, low-A by high-B, high-A by low-B, high by high) are formed by the same structure one level down, until the recursion reaches 2x2 cells built from single-bit ANDs and half adders. At every level, three ripple-carry adders merge the four partial products in a fixed order.

The first adder sums the two cross products. The second adder adds that sum to the upper half of the low-by-low product. The third adder adds the high-by-high product to an operand built from the upper half of the second sum and the folded carry of the first two adders. The lower result bits come straight from the low-by-low product and from the low half of the second sum.

A sleep input models a power-gated state at the logic level. While it is high, every product bit reads zero whatever the operands. When it falls, the valid product reappears combinationally.

Top module: `vx_mul_top`

## Requirements
- R1: With `sleep_en` low, `prod` equals the unsigned product `op_a * op_b` for every pair of 8-bit operands, as a 16-bit value.
- R2: Each 2x2 cell returns the 4-bit unsigned product of its two 2-bit inputs, formed from four AND terms and two half adders.
- R3: Each decomposition level (4x4 and 8x8) returns the exact product of its operands. Result bits [H-1:0] come from the low-by-low product, bits [W-1:H] from the low half of the second sum, and bits [2W-1:W] from the third sum, where W is the level width and H is W/2.
- R4: Every ripple-carry adder in the tree returns a carry-out and a sum equal to the sum of its two inputs and its carry-in.
- R5: At every level, the carry of the cross-product adder and the carry of the second adder are never both set. Their OR sits at bit H of the third adder's operand, so the second adder's carry is never lost. An example case is `op_a`=11, `op_b`=15 at the 4x4 level.
- R6: At every level, the third adder never produces a carry-out.
- R7: With `sleep_en` high, all 16 bits of `prod` are 0 whatever the values of `op_a` and `op_b`.
- R8: When `sleep_en` falls, `prod` shows the correct product for the operands present, with no clock edge required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| sleep_en | input | 1 | 1 = sleep (product clamped to zero), 0 = active |
| prod | output | 16 | Unsigned product, or zero while sleeping |

## Verification
Immediate assertions placed in the adders, the 2x2 cells and each decomposition level check the internal arithmetic every time the operands change. They cover per-level exactness, adder sums, the mutual exclusion of the two lower carries and the absence of a third-adder carry. These internal properties are otherwise invisible at the ports. The bench covers the behaviour seen from outside. It sweeps the whole operand space in both power states and runs directed cases that provoke the carry-fold path. It also checks that leaving sleep restores the product immediately and that operands have no effect on the clamped output.

// File: rtl/vx_pkg.sv
package vx_pkg;

   typedef enum logic {
      PWR_ACTIVE = 1'b0,
      PWR_SLEEP  = 1'b1
   } pwr_state_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/vx_rca.sv
module vx_rca #(
   parameter int N = 4
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   input  logic         ci,
   output logic [N-1:0] s,
   output logic         co
);
   logic [N:0] cy;

   assign cy[0] = ci;

   for (genvar i = 0; i < N; i++) begin : g_fa
      logic hx;
      assign hx      = x[i] ^ y[i];
      assign s[i]    = hx ^ cy[i];
      assign cy[i+1] = (x[i] & y[i]) | (cy[i] & hx);
   end

   assign co = cy[N];

   always_comb begin
      // R4
      adder_sum_chk: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{N{1'b0}}, ci}))
         else $error("adder sum mismatch");
   end

endmodule

// File: rtl/vx_mul2.sv
module vx_mul2 (
   input  logic [1:0] a,
   input  logic [1:0] b,
   output logic [3:0] p
);
   logic t00, t01, t10, t11, hc;

   assign t00 = a[0] & b[0];
   assign t01 = a[0] & b[1];
   assign t10 = a[1] & b[0];
   assign t11 = a[1] & b[1];

   // half adder on the two middle terms
   assign p[0] = t00;
   assign p[1] = t01 ^ t10;
   assign hc   = t01 & t10;
   // half adder on the top term and its carry
   assign p[2] = t11 ^ hc;
   assign p[3] = t11 & hc;

   always_comb begin
      // R2
      cell_prod_chk: assert (p == ({2'b00, a} * {2'b00, b}))
         else $error("2x2 cell mismatch");
   end

endmodule

// File: rtl/vx_quad.sv
module vx_quad #(
   parameter int W = 4
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   if (W < 2 || !vx_pkg::is_pow2(W)) begin : g_bad_w
      $error("vx_quad: W must be a power of two of at least 2");
   end

   if (W == 2) begin : g_leaf
      vx_mul2 cell_i (
         .a (a),
         .b (b),
         .p (p)
      );
   end else begin : g_split
      localparam int H = W / 2;

      logic [W-1:0] p_ll, p_lh, p_hl, p_hh;
      logic [W-1:0] s1, s2, s3, op2, op3;
      logic         c1, c2, c3;

      vx_quad #(.W(H)) q_ll_i (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
      vx_quad #(.W(H)) q_lh_i (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
      vx_quad #(.W(H)) q_hl_i (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
      vx_quad #(.W(H)) q_hh_i (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));

      // cross terms
      vx_rca #(.N(W)) add_x_i (.x(p_lh), .y(p_hl), .ci(1'b0), .s(s1), .co(c1));

      // align upper half of the low-by-low product
      assign op2 = {{H{1'b0}}, p_ll[W-1:H]};
      vx_rca #(.N(W)) add_m_i (.x(s1), .y(op2), .ci(1'b0), .s(s2), .co(c2));

      // upper half: folded carry at its lowest bit, zeros above
      assign op3 = {{(H-1){1'b0}}, (c1 | c2), s2[W-1:H]};
      vx_rca #(.N(W)) add_h_i (.x(p_hh), .y(op3), .ci(1'b0), .s(s3), .co(c3));

      assign p = {s3, s2[H-1:0], p_ll[H-1:0]};

      always_comb begin
         // R5
         carry_excl_chk: assert (!(c1 && c2))
            else $error("both lower carries set");
         // R6
         top_carry_chk: assert (!c3)
            else $error("third adder carried out");
      end
   end

   always_comb begin
      // R3
      level_prod_chk: assert (p == ({{W{1'b0}}, a} * {{W{1'b0}}, b}))
         else $error("level product mismatch");
   end

endmodule

// File: rtl/vx_mul_top.sv
module vx_mul_top #(
   parameter int OPW = 8,
   localparam int PW = 2 * OPW
) (
   input  logic [OPW-1:0] op_a,
   input  logic [OPW-1:0] op_b,
   input  logic           sleep_en,
   output logic [PW-1:0]  prod
);
   import vx_pkg::*;

   if (OPW < 2 || !is_pow2(OPW)) begin : g_bad_opw
      $error("vx_mul_top: OPW must be a power of two of at least 2");
   end

   pwr_state_e    pstate;
   logic [PW-1:0] core_p;

   assign pstate = pwr_state_e'(sleep_en);

   vx_quad #(.W(OPW)) core_i (
      .a (op_a),
      .b (op_b),
      .p (core_p)
   );

   assign prod = (pstate == PWR_SLEEP) ? '0 : core_p;

   always_comb begin
      // R7
      sleep_clamp_chk: assert (!sleep_en || (prod == '0))
         else $error("product not clamped in sleep");
      // R1
      active_prod_chk: assert (sleep_en || (prod == ({{OPW{1'b0}}, op_a} * {{OPW{1'b0}}, op_b})))
         else $error("active product mismatch");
   end

endmodule

// File: tb/vx_mul_top_tb.sv
module vx_mul_top_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  op_a = '0;
   logic [7:0]  op_b = '0;
   logic        sleep_en = 1'b1;
   logic [15:0] prod;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   vx_mul_top dut_i (
      .op_a     (op_a),
      .op_b     (op_b),
      .sleep_en (sleep_en),
      .prod     (prod)
   );

   // {sleep, a, b, expected}
   localparam int NV = 18;
   localparam logic [32:0] VEC [0:NV-1] = '{
      {1'b0, 8'd0,   8'd0,   16'd0},      // R1 zero
      {1'b0, 8'd1,   8'd1,   16'd1},      // R1
      {1'b0, 8'd3,   8'd3,   16'd9},      // R2 single cell max
      {1'b0, 8'd2,   8'd3,   16'd6},      // R2
      {1'b0, 8'd255, 8'd255, 16'd65025},  // R1 max
      {1'b0, 8'd255, 8'd1,   16'd255},    // R1
      {1'b0, 8'd1,   8'd255, 16'd255},    // R1
      {1'b0, 8'd11,  8'd15,  16'd165},    // R5 carry fold at 4x4
      {1'b0, 8'd47,  8'd255, 16'd11985},  // R5 carry fold at 8x8
      {1'b0, 8'd15,  8'd15,  16'd225},    // R3 nibble max
      {1'b0, 8'd240, 8'd15,  16'd3600},   // R3 cross
      {1'b0, 8'd15,  8'd240, 16'd3600},   // R3 cross
      {1'b0, 8'd128, 8'd128, 16'd16384},  // R6
      {1'b0, 8'd170, 8'd85,  16'd14450},  // R4 alternating bits
      {1'b0, 8'd200, 8'd200, 16'd40000},  // R4
      {1'b0, 8'd37,  8'd91,  16'd3367},   // R1
      {1'b1, 8'd255, 8'd255, 16'd0},      // R7
      {1'b1, 8'd11,  8'd15,  16'd0}       // R7
   };

   task automatic check(input string req, input logic [15:0] exp);
      total++;
      if (prod !== exp) begin
         bad++;
         $display("FAIL %s a=%0d b=%0d sleep=%0b actual=%0d expected=%0d",
                  req, op_a, op_b, sleep_en, prod, exp);
      end
   endtask

   initial begin
      // reset: held asleep, output clamped (R7)
      op_a = 8'd200; op_b = 8'd77;
      repeat (3) @(negedge clk);
      check("R7", 16'd0);
      rst = 1'b0;

      // vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         sleep_en = VEC[i][32];
         op_a     = VEC[i][31:24];
         op_b     = VEC[i][23:16];
         #1;
         check("R1/R7 table", VEC[i][15:0]);
      end

      // R8: wake with operands already present, no clock edge needed
      @(negedge clk);
      sleep_en = 1'b1; op_a = 8'd93; op_b = 8'd201;
      #1 check("R7", 16'd0);
      sleep_en = 1'b0;
      #1 check("R8", 16'd18693);
      sleep_en = 1'b1;
      #1 check("R7", 16'd0);
      op_a = 8'd250;                 // R7 operand change has no effect
      #1 check("R7", 16'd0);
      sleep_en = 1'b0;
      #1 check("R8", 16'd50250);

      // exhaustive sweep in both power states
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               sleep_en = s[0];
               op_a = a[7:0];
               op_b = b[7:0];
               #1;
               if (s == 0) check("R1", 16'(a * b));
               else        check("R7", 16'd0);
            end
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule